// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit up-counter with a prescaler and a compare register, reached through a small byte-addressed register bus. Software sets a reference value and a mode word that enables the timer, picks the tick source and the prescale divisor, and arms the interrupt. The prescaler divides the system clock into ticks, and the counter advances by one on each tick. On the tick after the count equals the reference, the counter returns to zero and a sticky reference flag is raised. The interrupt output follows that flag, gated by the interrupt-enable bit.

Writes happen in a single cycle when `bus_wr` is high. Reads are combinational from `bus_addr` and have no side effects. Any write to the mode or reference register restarts the count under the new settings. Software may also load the counter directly. It clears event flags by writing ones to them.

Top module: `prt_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The registers sit at these byte offsets: mode 0x00, reference 0x04, capture 0x08, counter 0x0C and events 0x11 (the events appear in the low byte of `bus_rdata`). The capture register keeps whatever software writes to it. Any other offset reads 0.
- R3: Mode bit 0 enables the timer. Bits 2:1 select the tick source and bit 3 selects restart-on-reference. With bit 0 set, source code 1 and bit 3 set, the counter advances once every (mode[15:8]+1) clock cycles. The first step comes that many cycles after the configuring write.
- R4: Source code 2 multiplies the prescale divisor by 16.
- R5: When mode bit 0 is clear, or the source code is 0 or 3, or bit 3 is clear, the counter holds its value.
- R6: On a tick where the counter equals the reference, the counter returns to 0 and event bit 1 is set. A reference of 0 therefore matches on every tick.
- R7: `irq` is high exactly while mode bit 4 and event bit 1 are both set.
- R8: A write to the events register clears each event bit that is 1 in the written data and leaves the other bits unchanged. If a match sets bit 1 on the same edge as a write that clears it, the bit stays set.
- R9: A mode write that changes bit 0 from 1 to 0 clears both the mode and reference registers. Any other mode write stores the written value.
- R10: A write to the mode or reference register resets the counter and the prescaler to 0.
- R11: A counter write loads the written value. It takes priority over a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| irq | output | 1 | Reference interrupt |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same edge as a hardware match. Over a normal reference period, that edge is a single clock cycle wide. The stimulus makes it certain by setting the reference to 0 with a divisor of 1, so every cycle is a match, and then writes a clear into that stream. The long divisors of the divide-by-16 source are also checked one cycle before and exactly on the first step. This confirms the product of the two divisors rather than either one alone.

// File: rtl/prt_pkg.sv
package prt_pkg;
   localparam int BUS_W  = 16;
   localparam int ADDR_W = 5;

   // byte offsets decoded by the register file
   localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

   // mode word field positions
   localparam int MB_EN      = 0;
   localparam int MB_SRC_LO  = 1;
   localparam int MB_RESTART = 3;
   localparam int MB_IRQEN   = 4;
   localparam int MB_PS_LO   = 8;

   // event bits
   localparam int EV_W   = 2;
   localparam int EV_CAP = 0;
   localparam int EV_REF = 1;

   typedef enum logic [1:0] {
      SRC_STOP0 = 2'd0,
      SRC_SYS   = 2'd1,
      SRC_SYS16 = 2'd2,
      SRC_STOP3 = 2'd3
   } src_e;
endpackage

// File: rtl/prt_presc.sv
module prt_presc #(
   parameter int PS_W      = 8,
   parameter int EXT_SHIFT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  logic [PS_W-1:0] ps,
   input  logic            ext,
   output logic            tick
);
   localparam int PC_W = PS_W + EXT_SHIFT;

   if (PS_W < 1 || PS_W > 8) begin : g_bad_ps
      $error("prt_presc: PS_W must lie in 1..8");
   end
   if (EXT_SHIFT < 0 || EXT_SHIFT > 8) begin : g_bad_shift
      $error("prt_presc: EXT_SHIFT must lie in 0..8");
   end

   logic [PC_W-1:0] pcnt;
   logic [PC_W-1:0] last;
   logic [PC_W:0]   base;
   logic [PC_W:0]   span;

   assign base = {{(EXT_SHIFT + 1){1'b0}}, ps} + {{PC_W{1'b0}}, 1'b1};

   if (EXT_SHIFT == 0) begin : g_plain
      assign span = base;
   end else begin : g_ext
      assign span = ext ? (base << EXT_SHIFT) : base;
   end

   assign last = PC_W'(span - {{PC_W{1'b0}}, 1'b1});
   assign tick = run && !restart && (pcnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               pcnt <= '0;
      else if (restart || !run || pcnt == last) pcnt <= '0;
      else                                      pcnt <= pcnt + 1'b1;
   end

   assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pcnt == '0));
   assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart) |-> (pcnt <= last));
   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0));
endmodule

// File: rtl/prt_count.sv
module prt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] ref_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("prt_count: CNT_W must lie in 2..16");
   end

   assign hit = tick && !load && (cnt == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (load)    cnt <= load_val;
      else if (tick)    cnt <= hit ? '0 : cnt + 1'b1;
   end

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart && !load) |=> $stable(cnt));
   assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !restart) |=> (cnt == $past(load_val)));
endmodule

// File: rtl/prt_regs.sv
module prt_regs
   import prt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              hit,
   output logic [BUS_W-1:0]  rdata,
   output logic [CNT_W-1:0]  ref_val,
   output logic              run,
   output logic [PS_W-1:0]   ps,
   output logic              ext,
   output logic              cfg_wr,
   output logic              cnt_ld,
   output logic              irq
);
   if (MB_PS_LO + PS_W > BUS_W) begin : g_bad_ps
      $error("prt_regs: prescale field exceeds the mode word");
   end

   logic [BUS_W-1:0] mode_q;
   logic [CNT_W-1:0] ref_q;
   logic [CNT_W-1:0] cap_q;
   logic [EV_W-1:0]  ev_q;
   logic             mode_wr, ref_wr, cap_wr, ev_wr, shut;
   src_e             src;

   assign mode_wr = wr && (addr == OFS_MODE);
   assign ref_wr  = wr && (addr == OFS_REF);
   assign cap_wr  = wr && (addr == OFS_CAP);
   assign ev_wr   = wr && (addr == OFS_EVT);
   assign cnt_ld  = wr && (addr == OFS_CNT);
   assign cfg_wr  = mode_wr || ref_wr;
   assign shut    = mode_wr && mode_q[MB_EN] && !wdata[MB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
         cap_q  <= '0;
      end else begin
         if (shut) begin
            mode_q <= '0;
            ref_q  <= '0;
         end else begin
            if (mode_wr) mode_q <= wdata;
            if (ref_wr)  ref_q  <= wdata[CNT_W-1:0];
         end
         if (cap_wr) cap_q <= wdata[CNT_W-1:0];
      end
   end

   // one flag per event bit: a hardware set outranks a software clear
   for (genvar b = 0; b < EV_W; b++) begin : g_ev
      localparam bit IS_REF = (b == EV_REF);
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  flag_q <= 1'b0;
         else if (IS_REF && hit)      flag_q <= 1'b1;
         else if (ev_wr && wdata[b])  flag_q <= 1'b0;
      end
      assign ev_q[b] = flag_q;
   end

   assign src     = src_e'(mode_q[MB_SRC_LO +: 2]);
   assign run     = mode_q[MB_EN] && mode_q[MB_RESTART] &&
                    (src == SRC_SYS || src == SRC_SYS16);
   assign ext     = (src == SRC_SYS16);
   assign ps      = mode_q[MB_PS_LO +: PS_W];
   assign ref_val = ref_q;
   assign irq     = mode_q[MB_IRQEN] && ev_q[EV_REF];

   always_comb begin
      case (addr)
         OFS_MODE: rdata = mode_q;
         OFS_REF:  rdata = BUS_W'(ref_q);
         OFS_CAP:  rdata = BUS_W'(cap_q);
         OFS_CNT:  rdata = BUS_W'(cnt);
         OFS_EVT:  rdata = BUS_W'(ev_q);
         default:  rdata = '0;
      endcase
   end

   assert_shut_R9: assert property (@(posedge clk) disable iff (!rst_n)
      shut |=> (mode_q == '0 && ref_q == '0));
   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wr && wdata[EV_REF] && !hit) |=> !ev_q[EV_REF]);
   assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ev_q[EV_REF]);
   assert_capquiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_wr |=> $stable(cap_q));
endmodule

// File: rtl/prt_timer.sv
module prt_timer
   import prt_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PS_W      = 8,
   parameter int EXT_SHIFT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   logic [CNT_W-1:0] cnt, ref_val;
   logic [PS_W-1:0]  ps;
   logic             hit, run, ext, cfg_wr, cnt_ld, tick;

   prt_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .cnt(cnt), .hit(hit), .rdata(bus_rdata),
      .ref_val(ref_val), .run(run), .ps(ps), .ext(ext),
      .cfg_wr(cfg_wr), .cnt_ld(cnt_ld), .irq(irq)
   );

   prt_presc #(.PS_W(PS_W), .EXT_SHIFT(EXT_SHIFT)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(cfg_wr),
      .ps(ps), .ext(ext), .tick(tick)
   );

   prt_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(cfg_wr),
      .load(cnt_ld), .load_val(bus_wdata[CNT_W-1:0]),
      .ref_val(ref_val), .cnt(cnt), .hit(hit)
   );

   assert_irqfall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bus_wr) |=> irq);
endmodule

// File: tb/test_prt_timer.sv
module test_prt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = 5'h00;
   logic [15:0] bus_wdata = 16'h0000;
   logic [15:0] bus_rdata;
   logic        irq;

   always #10 clk = ~clk;

   prt_timer i_prt_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                          A_CNT = 5'h0C, A_EVT = 5'h11;

   typedef struct {
      logic [4:0]  a;
      logic [15:0] d;
      logic        i;
      string       tag;
   } item_t;

   item_t q[$];
   bit    busy = 1'b0;
   bit    done = 1'b0;
   int    checks = 0;
   int    errors = 0;

   // driver side: queue an expected read and wait for the monitor
   task automatic expect_rd(input logic [4:0] a, input logic [15:0] d,
                            input logic i, input string tag);
      item_t it;
      it.a = a; it.d = d; it.i = i; it.tag = tag;
      q.push_back(it);
      wait (q.size() == 0 && !busy);
   endtask

   // call just after a falling edge; returns one falling edge later
   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops each expectation and compares against the ports
   initial begin
      forever begin
         item_t it;
         wait (q.size() > 0);
         busy = 1'b1;
         it = q.pop_front();
         bus_addr = it.a;
         #1;
         checks++;
         if (bus_rdata !== it.d || irq !== it.i) begin
            errors++;
            $display("FAIL %s: addr %h got rdata %h irq %b, expected rdata %h irq %b",
                     it.tag, it.a, bus_rdata, irq, it.d, it.i);
         end
         busy = 1'b0;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got a hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      expect_rd(A_MODE, 16'h0000, 1'b0, "R1 mode");
      expect_rd(A_REF,  16'h0000, 1'b0, "R1 ref");
      expect_rd(A_CAP,  16'h0000, 1'b0, "R1 capture");
      expect_rd(A_CNT,  16'h0000, 1'b0, "R1 counter");
      expect_rd(A_EVT,  16'h0000, 1'b0, "R1 events");

      // R2 map, capture storage, unmapped offsets
      wr(A_CAP, 16'h1234);
      wr(A_REF, 16'h0005);
      expect_rd(A_CAP,  16'h1234, 1'b0, "R2 capture");
      expect_rd(A_REF,  16'h0005, 1'b0, "R2 ref");
      expect_rd(5'h14,  16'h0000, 1'b0, "R2 unmapped 14");
      expect_rd(5'h10,  16'h0000, 1'b0, "R2 unmapped 10");
      expect_rd(5'h01,  16'h0000, 1'b0, "R2 unmapped 01");

      // R3 / R6 / R7: divisor 1, ref 5
      wr(A_MODE, 16'h001B);
      expect_rd(A_MODE, 16'h001B, 1'b0, "R2 mode");
      cyc(3);
      expect_rd(A_CNT, 16'h0003, 1'b0, "R3 count step");
      cyc(3);
      expect_rd(A_CNT, 16'h0000, 1'b1, "R6 wrap");
      expect_rd(A_EVT, 16'h0002, 1'b1, "R6 event set");

      // R8 write-one-to-clear
      wr(A_EVT, 16'h0001);
      expect_rd(A_EVT, 16'h0002, 1'b1, "R8 other bit kept");
      wr(A_EVT, 16'h0002);
      expect_rd(A_EVT, 16'h0000, 1'b0, "R8 cleared");
      expect_rd(A_CNT, 16'h0002, 1'b0, "R3 count continues");

      // R10 restart, R7 gating
      wr(A_MODE, 16'h000B);
      expect_rd(A_CNT, 16'h0000, 1'b0, "R10 restart on mode write");
      cyc(6);
      expect_rd(A_EVT, 16'h0002, 1'b0, "R7 irq gated off");
      wr(A_MODE, 16'h001B);
      expect_rd(A_CNT, 16'h0000, 1'b1, "R7 irq on enable");

      // R3 prescale divisor 3
      wr(A_EVT, 16'h0003);
      wr(A_MODE, 16'h021B);
      cyc(2);
      expect_rd(A_CNT, 16'h0000, 1'b0, "R3 before step div3");
      cyc(1);
      expect_rd(A_CNT, 16'h0001, 1'b0, "R3 step div3");
      cyc(3);
      expect_rd(A_CNT, 16'h0002, 1'b0, "R3 second step div3");

      // R4 divide by 16 and by 32
      wr(A_MODE, 16'h001D);
      cyc(15);
      expect_rd(A_CNT, 16'h0000, 1'b0, "R4 before step div16");
      cyc(1);
      expect_rd(A_CNT, 16'h0001, 1'b0, "R4 step div16");
      wr(A_MODE, 16'h011D);
      cyc(31);
      expect_rd(A_CNT, 16'h0000, 1'b0, "R4 before step div32");
      cyc(1);
      expect_rd(A_CNT, 16'h0001, 1'b0, "R4 step div32");

      // R5 stopped configurations, R11 load
      wr(A_MODE, 16'h0019);
      wr(A_CNT, 16'h0007);
      cyc(20);
      expect_rd(A_CNT, 16'h0007, 1'b0, "R5 source code 0");
      wr(A_MODE, 16'h001F);
      wr(A_CNT, 16'h0007);
      cyc(20);
      expect_rd(A_CNT, 16'h0007, 1'b0, "R5 source code 3");
      wr(A_MODE, 16'h0013);
      wr(A_CNT, 16'h0007);
      cyc(20);
      expect_rd(A_CNT, 16'h0007, 1'b0, "R5 restart bit clear");

      // R9 enable 1->0 clears mode and ref
      wr(A_MODE, 16'h001A);
      expect_rd(A_MODE, 16'h0000, 1'b0, "R9 mode cleared");
      expect_rd(A_REF,  16'h0000, 1'b0, "R9 ref cleared");
      expect_rd(A_CAP,  16'h1234, 1'b0, "R2 capture untouched");
      wr(A_MODE, 16'h021A);
      expect_rd(A_MODE, 16'h021A, 1'b0, "R9 plain store");
      wr(A_CNT, 16'h0007);
      cyc(20);
      expect_rd(A_CNT, 16'h0007, 1'b0, "R5 enable clear");

      // R11 load beats a tick while running
      wr(A_REF, 16'h0005);
      wr(A_EVT, 16'h0003);
      wr(A_MODE, 16'h001B);
      wr(A_CNT, 16'h0004);
      expect_rd(A_CNT, 16'h0004, 1'b0, "R11 load over tick");
      cyc(1);
      expect_rd(A_CNT, 16'h0005, 1'b0, "R11 count after load");
      cyc(1);
      expect_rd(A_CNT, 16'h0000, 1'b1, "R6 wrap after load");
      expect_rd(A_EVT, 16'h0002, 1'b1, "R6 event after load");

      // R6 ref 0 matches every tick; R8 set beats clear
      wr(A_REF, 16'h0000);
      cyc(1);
      wr(A_EVT, 16'h0002);
      expect_rd(A_EVT, 16'h0002, 1'b1, "R8 set wins over clear");
      expect_rd(A_CNT, 16'h0000, 1'b1, "R6 ref zero holds at 0");

      // R9 disable from enabled; flag stays but irq drops (R7)
      wr(A_MODE, 16'h0000);
      expect_rd(A_MODE, 16'h0000, 1'b0, "R9 disable mode");
      expect_rd(A_EVT,  16'h0002, 1'b0, "R7 irq follows enable");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule